// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two escalation stages. A counter runs on the system clock from the moment software last restarted it. When the count reaches the interval picked by a two-bit select field, the block sets an interrupt flag. The interrupt line to the CPU follows that flag only while the interrupt enable is set. From that same moment a fixed grace window opens. If software does not restart the watchdog before the window closes, and the reset enable is set, the block drives a system reset request. A sticky status bit then records that this watchdog caused the reset.

Software keeps the block quiet by pulsing the restart strobe more often than the selected interval. The interrupt stage gives a well-behaved handler a last chance to recover. The reset stage catches code that has lost control completely. The reset output can be a single-cycle pulse or a pulse stretched to a fixed length. The length is chosen at elaboration.

Top module: `wdt_two_stage`

## Requirements
- R1: While and directly after reset, `irq_flag`, `irq`, `wdrst_flag` and `wd_rst` are all 0.
- R2: The select field `tsel` picks the interval: 2'b00 gives 2^EXP0 cycles, 2'b01 gives 2^EXP1, 2'b10 gives 2^EXP2 and 2'b11 gives 2^EXP3 (by default 2^15, 2^18, 2^21 and 2^24). `irq_flag` becomes 1 exactly that many clock edges after the edge that sampled `kick` high, and not one edge earlier.
- R3: A high `kick` returns the count to zero. If `kick` is pulsed at intervals no longer than the selected interval, `irq_flag` never sets.
- R4: The timeout sets `irq_flag` whatever the value of `irq_en`. The output `irq` is 1 only while both `irq_flag` and `irq_en` are 1.
- R5: `irq_clr` clears `irq_flag` at the next edge. If a timeout occurs at the same edge as a clear, the timeout wins and the flag stays 1.
- R6: With `rst_en` at 1 and no `kick`, `wd_rst` becomes 1 exactly GRACE edges (512 by default) after the edge that set `irq_flag`. Clearing `irq_flag` does not stop this.
- R7: A `kick` sampled at any edge of the grace window cancels the pending reset. This includes the last edge of the window, where the reset would otherwise fire.
- R8: With `rst_en` at 0, `wd_rst` never asserts. The interval starts again at each timeout, so `irq_flag` sets once per interval.
- R9: `wd_rst` stays 1 for exactly RST_CYCLES consecutive cycles per watchdog reset.
- R10: `wdrst_flag` sets at the same edge as `wd_rst`. It stays 1 until `wdrst_clr` is sampled high.
- R11: When a watchdog reset fires, the count starts again from zero. The next timeout therefore follows one full interval after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tsel | input | 2 | Interval select (00 shortest, 11 longest) |
| irq_en | input | 1 | Lets `irq_flag` drive `irq` |
| rst_en | input | 1 | Enables the reset stage |
| kick | input | 1 | Restart strobe from software |
| irq_clr | input | 1 | Clears `irq_flag` |
| wdrst_clr | input | 1 | Clears `wdrst_flag` |
| irq_flag | output | 1 | Timeout flag |
| irq | output | 1 | Interrupt request to the CPU |
| wdrst_flag | output | 1 | Sticky bit: a watchdog reset happened |
| wd_rst | output | 1 | System reset request |

## Verification
The bench builds the block with interval exponents of 6, 7, 8 and 9, a grace window of 16 cycles and a three-cycle reset pulse. With these values every select code, the whole grace window and repeated timeouts fit in a few thousand cycles. Each edge of the window can be probed, including a restart on the very edge where the reset would fire. The stretched reset variant is built, so the hold counter and its exact length are exercised. Random restart gaps close to the interval limit and random enables are mixed with directed boundary cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int WDT_SEL_W   = 2;
   localparam int WDT_NUM_SEL = 1 << WDT_SEL_W;
   typedef logic [WDT_SEL_W-1:0] wdt_sel_t;
endpackage

// File: rtl/wdt_timebase.sv
// Free-running interval counter with a selectable terminal count.
module wdt_timebase #(
   parameter int EXP0 = 15,
   parameter int EXP1 = 18,
   parameter int EXP2 = 21,
   parameter int EXP3 = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  wdt_pkg::wdt_sel_t    tsel,
   input  logic                 restart,
   output logic                 hit
);
   localparam int CNT_W = EXP3;
   localparam int EXPS [wdt_pkg::WDT_NUM_SEL] = '{EXP0, EXP1, EXP2, EXP3};

   logic [CNT_W-1:0]                    cnt_q;
   logic [wdt_pkg::WDT_NUM_SEL-1:0]     at_term;

   // One terminal comparator per interval choice
   for (genvar g = 0; g < wdt_pkg::WDT_NUM_SEL; g++) begin : g_term
      localparam logic [CNT_W-1:0] TERM = CNT_W'((64'd1 << EXPS[g]) - 64'd1);
      assign at_term[g] = (cnt_q == TERM);
   end

   // A restart in the same cycle overrides the timeout
   assign hit = at_term[tsel] && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || hit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_grace.sv
// Grace window: opens on a timeout and fires unless cancelled.
module wdt_grace #(
   parameter int GRACE = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic kick,
   input  logic rst_en,
   output logic pending,
   output logic fire
);
   localparam int GW = (GRACE > 1) ? $clog2(GRACE) : 1;
   localparam logic [GW-1:0] LAST = GW'(GRACE - 1);

   logic [GW-1:0] gcnt_q;
   logic          pend_q;

   assign fire    = pend_q && (gcnt_q == LAST) && rst_en && !kick;
   assign pending = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         gcnt_q <= '0;
      end else begin
         if (kick || fire || !rst_en) begin
            pend_q <= 1'b0;
         end else if (arm) begin
            pend_q <= 1'b1;
         end
         if (arm) begin
            gcnt_q <= '0;
         end else if (pend_q) begin
            gcnt_q <= gcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdt_rst_gen.sv
// Reset output: single-cycle pulse or stretched to RST_CYCLES.
module wdt_rst_gen #(
   parameter int RST_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic wd_rst
);
   if (RST_CYCLES == 1) begin : g_pulse
      logic rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_q <= 1'b0;
         else        rst_q <= fire;
      end
      assign wd_rst = rst_q;
   end else begin : g_stretch
      localparam int HW = $clog2(RST_CYCLES + 1);
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (fire) begin
            hold_q <= HW'(RST_CYCLES);
         end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
         end
      end
      assign wd_rst = (hold_q != '0);
   end
endmodule

// File: rtl/wdt_flags.sv
// Interrupt flag (set wins over clear) and sticky reset-cause bit.
module wdt_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout,
   input  logic irq_clr,
   input  logic fire,
   input  logic wdrst_clr,
   output logic irq_flag,
   output logic wdrst_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag   <= 1'b0;
         wdrst_flag <= 1'b0;
      end else begin
         if (timeout)      irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;
         if (fire)           wdrst_flag <= 1'b1;
         else if (wdrst_clr) wdrst_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/wdt_two_stage.sv
// Two-stage watchdog: interrupt at the interval, reset after a grace window.
module wdt_two_stage #(
   parameter int EXP0       = 15,
   parameter int EXP1       = 18,
   parameter int EXP2       = 21,
   parameter int EXP3       = 24,
   parameter int GRACE      = 512,
   parameter int RST_CYCLES = 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [wdt_pkg::WDT_SEL_W-1:0]    tsel,
   input  logic                             irq_en,
   input  logic                             rst_en,
   input  logic                             kick,
   input  logic                             irq_clr,
   input  logic                             wdrst_clr,
   output logic                             irq_flag,
   output logic                             irq,
   output logic                             wdrst_flag,
   output logic                             wd_rst
);
   initial begin : elab_chk
      if (!(EXP0 >= 1 && EXP0 < EXP1 && EXP1 < EXP2 && EXP2 < EXP3 && EXP3 <= 32))
         $fatal(1, "interval exponents must rise strictly and stay within 1..32");
      if (GRACE < 2 || (64'd1 << EXP0) <= 64'(GRACE + RST_CYCLES))
         $fatal(1, "grace window must be at least 2 and shorter than the shortest interval");
      if (RST_CYCLES < 1)
         $fatal(1, "reset length must be at least one cycle");
   end

   logic tb_hit;
   logic wd_fire;
   logic grace_pending;

   wdt_timebase #(
      .EXP0 (EXP0), .EXP1 (EXP1), .EXP2 (EXP2), .EXP3 (EXP3)
   ) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .tsel    (tsel),
      .restart (kick || wd_fire),
      .hit     (tb_hit)
   );

   wdt_grace #(.GRACE(GRACE)) u_grace (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (tb_hit && rst_en),
      .kick    (kick),
      .rst_en  (rst_en),
      .pending (grace_pending),
      .fire    (wd_fire)
   );

   wdt_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (wd_fire),
      .wd_rst (wd_rst)
   );

   wdt_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .timeout    (tb_hit),
      .irq_clr    (irq_clr),
      .fire       (wd_fire),
      .wdrst_clr  (wdrst_clr),
      .irq_flag   (irq_flag),
      .wdrst_flag (wdrst_flag)
   );

   assign irq = irq_flag && irq_en;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
   parameter int RST_CYCLES = 1
) (
   input logic clk,
   input logic rst_n,
   input logic irq_en,
   input logic rst_en,
   input logic kick,
   input logic irq_clr,
   input logic wdrst_clr,
   input logic irq_flag,
   input logic irq,
   input logic wdrst_flag,
   input logic wd_rst,
   input logic timeout,
   input logic pending
);
   int run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= 0;
      else if (wd_rst) run_len <= run_len + 1;
      else             run_len <= 0;
   end

   // R3: a restart leaves no room for a timeout at the next edge
   a_r3_kick_blocks_flag: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !$rose(irq_flag));
   // R4
   a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_flag);
   a_r4_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en);
   // R5
   a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !timeout) |=> !irq_flag);
   // R6
   a_r6_fire_from_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> $past(pending));
   // R7
   a_r7_kick_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !$rose(wd_rst));
   // R8
   a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> $past(rst_en));
   // R9
   a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= RST_CYCLES);
   // R10
   a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> wdrst_flag);
   a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wdrst_flag) && !$past(wdrst_clr)) |-> wdrst_flag);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_en     (irq_en),
   .rst_en     (rst_en),
   .kick       (kick),
   .irq_clr    (irq_clr),
   .wdrst_clr  (wdrst_clr),
   .irq_flag   (irq_flag),
   .irq        (irq),
   .wdrst_flag (wdrst_flag),
   .wd_rst     (wd_rst),
   .timeout    (tb_hit),
   .pending    (grace_pending)
);

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
   localparam int E0 = 6, E1 = 7, E2 = 8, E3 = 9;
   localparam int GR = 16;
   localparam int RC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] tsel = 2'b00;
   logic       irq_en = 1'b0, rst_en = 1'b0, kick = 1'b0;
   logic       irq_clr = 1'b0, wdrst_clr = 1'b0;
   logic       irq_flag, irq, wdrst_flag, wd_rst;

   int checks = 0;
   int errors = 0;
   logic saw_rst, saw_irq;

   always #5 clk = ~clk;

   wdt_two_stage #(
      .EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3), .GRACE(GR), .RST_CYCLES(RC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tsel(tsel), .irq_en(irq_en), .rst_en(rst_en),
      .kick(kick), .irq_clr(irq_clr), .wdrst_clr(wdrst_clr),
      .irq_flag(irq_flag), .irq(irq), .wdrst_flag(wdrst_flag), .wd_rst(wd_rst)
   );

   function automatic int period(input int s);
      case (s)
         0: return 1 << E0;
         1: return 1 << E1;
         2: return 1 << E2;
         default: return 1 << E3;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic adv(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         saw_rst = saw_rst | wd_rst;
         saw_irq = saw_irq | irq_flag;
      end
   endtask

   task automatic kick_now();
      kick = 1'b1; adv(1); kick = 1'b0;
   endtask

   task automatic clr_irq();
      irq_clr = 1'b1; adv(1); irq_clr = 1'b0;
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int t;
      int d;
      void'($urandom(32'd20240611));
      saw_rst = 1'b0; saw_irq = 1'b0;
      adv(3);
      // R1: reset state
      chk("R1 irq_flag", irq_flag, 0);
      chk("R1 wd_rst", wd_rst, 0);
      chk("R1 wdrst_flag", wdrst_flag, 0);
      rst_n = 1'b1;
      adv(1);
      chk("R1 irq after release", irq, 0);

      // R2, R4: every select code plus random ones
      for (int k = 0; k < 8; k++) begin
         int s;
         s = (k < 4) ? k : int'($urandom_range(0, 3));
         tsel = 2'(s);
         irq_en = 1'($urandom_range(0, 1));
         t = period(s);
         kick_now();
         adv(t - 1);
         chk("R2 flag before interval", irq_flag, 0);
         adv(1);
         chk("R2 flag at interval", irq_flag, 1);
         chk("R4 irq follows enable", irq, int'(irq_en));
         clr_irq();
         chk("R5 flag cleared", irq_flag, 0);
      end

      // R3: restarts at random gaps up to the interval never time out
      tsel = 2'($urandom_range(0, 3));
      t = period(tsel);
      saw_irq = 1'b0;
      for (int k = 0; k < 10; k++) begin
         d = (k == 0) ? t - 1 : int'($urandom_range(t - 8, t - 1));
         kick_now();
         adv(d);
      end
      kick_now();
      chk("R3 no timeout with regular restarts", saw_irq, 0);

      // R5: timeout at the same edge as a clear keeps the flag
      tsel = 2'b00; t = period(0);
      kick_now();
      adv(t - 1);
      irq_clr = 1'b1; adv(1); irq_clr = 1'b0;
      chk("R5 set wins over clear", irq_flag, 1);
      clr_irq();

      // R6, R9, R10, R11: full escalation
      rst_en = 1'b1;
      kick_now();
      adv(t);
      chk("R6 flag opens window", irq_flag, 1);
      adv(GR - 1);
      chk("R6 no reset before window end", wd_rst, 0);
      adv(1);
      chk("R6 reset at window end", wd_rst, 1);
      chk("R10 sticky set with reset", wdrst_flag, 1);
      adv(RC - 1);
      chk("R9 reset still held", wd_rst, 1);
      adv(1);
      chk("R9 reset released after length", wd_rst, 0);
      clr_irq();
      adv(t - RC - 2);
      chk("R11 no timeout before full interval", irq_flag, 0);
      adv(1);
      chk("R11 timeout one interval after reset", irq_flag, 1);
      kick_now();
      clr_irq();
      chk("R10 sticky persists", wdrst_flag, 1);
      wdrst_clr = 1'b1; adv(1); wdrst_clr = 1'b0;
      chk("R10 sticky cleared", wdrst_flag, 0);

      // R7: restart anywhere in the window, last edge included
      for (int k = 0; k < 6; k++) begin
         d = (k == 0) ? GR - 1 : int'($urandom_range(0, GR - 2));
         kick_now();
         adv(t);
         adv(d);
         kick_now();
         saw_rst = 1'b0;
         adv(GR + RC + 2);
         chk("R7 restart cancels reset", saw_rst, 0);
         clr_irq();
      end
      chk("R7 no sticky after cancel", wdrst_flag, 0);

      // R8: reset stage disabled, interrupt recurs each interval
      rst_en = 1'b0; irq_en = 1'b1;
      tsel = 2'($urandom_range(0, 1));
      t = period(tsel);
      kick_now();
      saw_rst = 1'b0;
      adv(t);
      chk("R8 first timeout", irq, 1);
      clr_irq();
      adv(t - 2);
      chk("R8 quiet between timeouts", irq_flag, 0);
      adv(1);
      chk("R8 second timeout", irq_flag, 1);
      adv(GR + RC + 2);
      chk("R8 no reset when disabled", saw_rst, 0);
      chk("R8 no sticky when disabled", wdrst_flag, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule